// File: doc/BRIEF.md
# Programmable Load Clock Divider

This block takes a fast clock and produces a slower load clock whose period is a selectable whole number of fast-clock cycles. The modulus comes from a 3-bit code, and the output stays high for exactly half the period even when the modulus is odd. For odd moduli the block adds a half-cycle extension that is registered on the falling edge of the fast clock.

The code is sampled only when one load-clock period ends and the next begins, so the code source can change it at any time without producing a short pulse. A suppress input parks the output at logic low. When suppress is released, the divider starts a fresh, full-length period at the next rising edge.

Top module: `load_clock_divider`

## Requirements
- R1: The code selects the modulus as follows: 0 gives 3, 1 gives 4, 2 gives 5, 3 gives 6, 4 gives 8 and 5 gives 10. One load-clock period lasts exactly that many fast-clock cycles, and each period begins with the output going high on a fast rising edge.
- R2: For every legal modulus N, the high phase and the low phase each last exactly N fast-clock half-periods, including for N = 3 and N = 5.
- R3: Codes 6 and 7 are ignored. The divider keeps running with the modulus it last accepted.
- R4: A code change is applied only at the start of the next load period. The period in progress completes with the old modulus, and the output rises only at a period start.
- R5: While suppress is high, the output is low from the second fast rising edge at which suppress is sampled high onward.
- R6: After suppress is sampled low, the output rises at that same fast rising edge. The first high phase lasts the full N half-periods of the code present at that edge.
- R7: Active-low reset forces the output low at once. At the first fast rising edge after release, a full period starts using the code present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fastClk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| modSel | input | 3 | Modulus code (0..5 legal) |
| suppress | input | 1 | Forces the load clock low while high |
| loadClk | output | 1 | Divided load clock with 50% duty cycle |

## Verification
A wrong cycle count or a wrongly latched modulus shows up within one load period as an unequal high/low split or a wrong period length. The bench measures both phases in fast half-periods from the output's own edges. A broken falling-edge extension shows up only for odd codes, as a high phase one half-period short. A code latched at the wrong moment shows up in the period during which the code was changed, as a truncated first phase. A suppress or restart fault shows up within two fast cycles as a high level, or as a late or shortened first pulse.

// File: rtl/ldiv_pkg.sv
`timescale 1ns/1ps
package ldiv_pkg;
  localparam int CODE_W    = 3;
  localparam int CNT_W     = 4;
  localparam int NUM_MODES = 6;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic setHigh;    // value the rising-edge phase register takes next
    logic oddNext;    // modulus used from the next edge is odd
    logic newPeriod;  // next edge begins a fresh period
  } strobe_t;

  function automatic logic codeLegal(input code_t c);
    return int'(c) < NUM_MODES;
  endfunction

  function automatic cnt_t codeToMod(input code_t c);
    case (int'(c))
      0:       return cnt_t'(3);
      1:       return cnt_t'(4);
      2:       return cnt_t'(5);
      3:       return cnt_t'(6);
      4:       return cnt_t'(8);
      default: return cnt_t'(10);
    endcase
  endfunction
endpackage

// File: rtl/ldiv_ctrl.sv
`timescale 1ns/1ps
module ldiv_ctrl
  import ldiv_pkg::*;
#(
  parameter code_t RST_CODE = code_t'(1)
) (
  input  logic    fastClk,
  input  logic    rstN,
  input  code_t   modSel,
  input  logic    suppress,
  output strobe_t stb
);
  cnt_t cnt, curMod, nextMod, cntNext, halfNext;
  logic running, boundary;

  always_comb begin
    // Idle (after reset or suppress) counts as a boundary
    boundary = !running || (cnt == curMod - cnt_t'(1));
    nextMod  = curMod;
    if (boundary && codeLegal(modSel)) nextMod = codeToMod(modSel);
    cntNext  = boundary ? '0 : cnt + cnt_t'(1);
    halfNext = nextMod >> 1;
    stb.newPeriod = boundary && !suppress;
    stb.setHigh   = !suppress && (cntNext < halfNext);
    stb.oddNext   = nextMod[0];
  end

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
      curMod  <= codeToMod(RST_CODE);
    end else if (suppress) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt     <= cntNext;
      running <= 1'b1;
      curMod  <= nextMod;
    end
  end
endmodule

// File: rtl/ldiv_dp.sv
`timescale 1ns/1ps
module ldiv_dp
  import ldiv_pkg::*;
#(
  parameter bit ODD_STAGE = 1'b1
) (
  input  logic    fastClk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    loadClk
);
  logic riseQ, oddQ, fallQ;

  always_ff @(posedge fastClk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= 1'b0;
      oddQ  <= 1'b0;
    end else begin
      riseQ <= stb.setHigh;
      if (stb.newPeriod) oddQ <= stb.oddNext;
    end
  end

  generate
    if (ODD_STAGE) begin : g_oddStage
      // Half-cycle delayed copy stretches the high phase by one half-period
      always_ff @(negedge fastClk or negedge rstN) begin
        if (!rstN) fallQ <= 1'b0;
        else       fallQ <= riseQ & oddQ;
      end
    end else begin : g_noOddStage
      assign fallQ = 1'b0;
    end
  endgenerate

  assign loadClk = riseQ | fallQ;
endmodule

// File: rtl/load_clock_divider.sv
`timescale 1ns/1ps
module load_clock_divider
  import ldiv_pkg::*;
(
  input  logic       fastClk,
  input  logic       rstN,
  input  logic [2:0] modSel,
  input  logic       suppress,
  output logic       loadClk
);
  strobe_t stb;

  ldiv_ctrl #(.RST_CODE(code_t'(1))) u_ctrl (
    .fastClk  (fastClk),
    .rstN     (rstN),
    .modSel   (code_t'(modSel)),
    .suppress (suppress),
    .stb      (stb)
  );

  ldiv_dp #(.ODD_STAGE(1'b1)) u_dp (
    .fastClk (fastClk),
    .rstN    (rstN),
    .stb     (stb),
    .loadClk (loadClk)
  );
endmodule

// File: rtl/load_clock_divider_chk.sv
`timescale 1ns/1ps
module load_clock_divider_chk
  import ldiv_pkg::*;
(
  input logic    fastClk,
  input logic    rstN,
  input logic    suppress,
  input logic    loadClk,
  input strobe_t stb
);
  // R1
  period_start_high_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    ($past(rstN) && $past(stb.newPeriod)) |-> loadClk);

  // R4
  rise_at_boundary_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    $rose(loadClk) |-> $past(stb.newPeriod));

  // R5
  suppress_low_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    (suppress && $past(suppress)) |-> !loadClk);

  // R6
  restart_high_chk: assert property (@(posedge fastClk) disable iff (!rstN)
    ($past(rstN) && $fell(suppress)) |=> loadClk);
endmodule

bind load_clock_divider load_clock_divider_chk u_chk (
  .fastClk  (fastClk),
  .rstN     (rstN),
  .suppress (suppress),
  .loadClk  (loadClk),
  .stb      (stb)
);

// File: tb/load_clock_divider_test.sv
`timescale 1ns/1ps
module load_clock_divider_test;
  logic       fastClk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modSel = 3'd1;
  logic       suppress = 1'b0;
  logic       loadClk;

  int total = 0;
  int bad = 0;
  realtime t0, t1, t2, t3;

  typedef struct packed {
    logic [2:0] code;
    int         expN;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 3}, '{3'd1, 4}, '{3'd2, 5}, '{3'd3, 6},
    '{3'd4, 8}, '{3'd5, 10}, '{3'd2, 5}, '{3'd0, 3}
  };

  load_clock_divider uut (
    .fastClk  (fastClk),
    .rstN     (rstN),
    .modSel   (modSel),
    .suppress (suppress),
    .loadClk  (loadClk)
  );

  always #2 fastClk = ~fastClk;  // 250 MHz

  function automatic int halves(input realtime a, input realtime b);
    return int'((b - a) / 2.0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int lo);
    @(posedge loadClk) t0 = $realtime;
    @(negedge loadClk) t1 = $realtime;
    @(posedge loadClk) t2 = $realtime;
    hi = halves(t0, t1);
    lo = halves(t1, t2);
  endtask

  initial begin
    repeat (100000) @(posedge fastClk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo, seen;
    // R7: output low while reset is held
    repeat (3) @(negedge fastClk);
    check("R7 low in reset", int'(loadClk), 0);
    rstN = 1'b1;
    @(posedge fastClk);
    #1 check("R7 high after release", int'(loadClk), 1);

    // R1/R2 table walk
    for (int i = 0; i < 8; i++) begin
      @(negedge fastClk) modSel = VECS[i].code;
      repeat (2) @(posedge loadClk);
      measure(hi, lo);
      check($sformatf("R1 period code %0d", VECS[i].code), hi + lo, 2 * VECS[i].expN);
      check($sformatf("R2 high code %0d", VECS[i].code), hi, VECS[i].expN);
      check($sformatf("R2 low code %0d", VECS[i].code), lo, VECS[i].expN);
    end

    // R3: illegal codes keep the modulus (3)
    @(negedge fastClk) modSel = 3'd6;
    repeat (2) @(posedge loadClk);
    measure(hi, lo);
    check("R3 code 6 ignored", hi + lo, 6);
    @(negedge fastClk) modSel = 3'd7;
    repeat (2) @(posedge loadClk);
    measure(hi, lo);
    check("R3 code 7 ignored", hi + lo, 6);

    // R4: change mid-period from 10 to 3
    @(negedge fastClk) modSel = 3'd5;
    repeat (2) @(posedge loadClk);
    @(posedge loadClk) t0 = $realtime;
    @(negedge fastClk) modSel = 3'd0;
    @(negedge loadClk) t1 = $realtime;
    @(posedge loadClk) t2 = $realtime;
    @(negedge loadClk) t3 = $realtime;
    check("R4 old high kept", halves(t0, t1), 10);
    check("R4 old low kept", halves(t1, t2), 10);
    check("R4 new high", halves(t2, t3), 3);

    // R5: suppress holds the output low
    @(negedge fastClk) begin suppress = 1'b1; modSel = 3'd2; end
    repeat (2) @(posedge fastClk);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      #1 if (loadClk) seen++;
      #2 if (loadClk) seen++;
      #1;
    end
    check("R5 low while suppressed", seen, 0);

    // R6: release gives a full first pulse of modulus 5
    @(negedge fastClk) suppress = 1'b0;
    @(posedge fastClk) t0 = $realtime;
    #1 check("R6 rises at release edge", int'(loadClk), 1);
    @(negedge loadClk) t1 = $realtime;
    @(posedge loadClk) t2 = $realtime;
    check("R6 first high full", halves(t0, t1), 5);
    check("R6 first low full", halves(t1, t2), 5);

    // R7: mid-run reset, restart with modulus 4
    @(posedge fastClk);
    #1 rstN = 1'b0;
    #0.5 check("R7 async low", int'(loadClk), 0);
    modSel = 3'd1;
    repeat (3) @(negedge fastClk);
    rstN = 1'b1;
    @(posedge fastClk) t0 = $realtime;
    #1 check("R7 restart high", int'(loadClk), 1);
    @(negedge loadClk) t1 = $realtime;
    check("R7 restart high length", halves(t0, t1), 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule